// File: doc/BRIEF.md
# Mixed Indexed / Direct Colour Pixel Merge

This block sits in the scan-out path of a framebuffer that keeps three planes side by side for every pixel. One plane holds an 8-bit palette index. One holds a 32-bit direct-colour word. The third is a 32-bit control word. For every pixel presented with a valid strobe, the block reads the top byte of the control word and chooses between two colours: the direct colour held in the direct-colour word, or the colour that an external 256-entry palette returns for the index. It packs the chosen colour into a 32-bit output word in red-first or blue-first order and emits it on a valid-qualified stream. There is no back-pressure.

The direct-colour word keeps its components low byte first: red is in the lowest byte, then green, then blue. The palette is reached through a synchronous read port. The block drives the address in the same cycle as the input pixel and expects the data one clock later. The block also tracks the raster position inside an active window whose width and height are configured up to a maximum of 1024 by 768. It tags each output pixel with start-of-line, end-of-line and end-of-frame markers. Fetching the planes from memory, generating display timing and scaling are done elsewhere.

Top module: `pixmerge`

## Requirements
- R1: When `in_ctrl_tag` (bits 31:24 of the control word) equals 0x03, the output colour is the direct colour, with red taken from `in_direct[7:0]`, green from `in_direct[15:8]` and blue from `in_direct[23:16]`.
- R2: Any other value of `in_ctrl_tag`, including near misses such as 0x02, 0x07, 0x13 and 0x83, selects the palette colour for `in_index`. The palette read data carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R3: In every cycle with `in_valid` high, `pal_rd_en` is high and `pal_rd_addr` equals `in_index`. The palette data is taken one clock edge later.
- R4: With `cfg_bgr` low the output is red in bits 23:16, green in 15:8 and blue in 7:0. With `cfg_bgr` high the output is blue in 23:16, green in 15:8 and red in 7:0.
- R5: Bits 31:24 of `out_pixel` are always zero.
- R6: `out_valid` rises exactly two clock edges after each sampled input pixel. Pixels leave in the order they arrived, one per cycle at full rate, and no pixel is lost or inserted.
- R7: After reset `out_valid`, `out_sol`, `out_eol`, `out_eof` and `out_pixel` are all zero, and the next input pixel is at column 0, row 0.
- R8: `out_sol` marks a pixel in column 0 and `out_eol` marks a pixel in the last column of the active width. The column counter wraps to 0 after the last column.
- R9: `out_eof` marks the last column of the last active row. The next pixel is at column 0, row 0 again.
- R10: A configured width of 0 or above 1024 acts as 1024. A configured height of 0 or above 768 acts as 768.
- R11: While no pixel is being delivered, `out_pixel` holds its last value, and `out_valid` and the markers stay low whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bgr | input | 1 | Static output order: 0 red-first, 1 blue-first |
| cfg_width | input | 11 | Active width in pixels (0 or >1024 means 1024) |
| cfg_height | input | 10 | Active height in rows (0 or >768 means 768) |
| in_valid | input | 1 | Input pixel strobe |
| in_index | input | 8 | Indexed-plane value of the pixel |
| in_direct | input | 24 | Direct-colour word, bits 23:0 (blue, green, red from high to low) |
| in_ctrl_tag | input | 8 | Top byte of the control word |
| pal_rd_en | output | 1 | Palette read enable |
| pal_rd_addr | output | 8 | Palette read address |
| pal_rd_data | input | 24 | Palette colour, red 23:16, green 15:8, blue 7:0, one cycle after the read |
| out_valid | output | 1 | Output pixel strobe |
| out_pixel | output | 32 | Packed output pixel |
| out_sol | output | 1 | Pixel is in column 0 |
| out_eol | output | 1 | Pixel is in the last active column |
| out_eof | output | 1 | Pixel is the last of the active frame |

## Verification
A pixel sampled at a rising edge has its palette address visible in the same cycle. Its palette data arrives after that edge, and its packed colour and markers appear after the second rising edge. The bench therefore drives on falling edges, checks the palette address one nanosecond after driving, and compares outputs on falling edges. Each pushed pixel gets its expected word and markers appended to an ordered queue, and every falling edge with `out_valid` high pops and compares one entry, so both the order and the two-edge delay are checked. A dedicated scenario samples `out_valid` low at the first falling edge and high at the second, and every scenario ends by confirming that the queue has drained.

// File: rtl/pixmerge_pkg.sv
package pixmerge_pkg;

  localparam int COMP_W = 8;
  localparam int NCOMP  = 3;
  localparam int RGB_W  = COMP_W * NCOMP;

  typedef logic [COMP_W-1:0] comp_t;

  typedef struct packed {
    comp_t red;
    comp_t grn;
    comp_t blu;
  } rgb_t;

  typedef struct packed {
    logic sol;
    logic eol;
    logic eof;
  } mark_t;

  typedef enum logic {
    SRC_PALETTE = 1'b0,
    SRC_DIRECT  = 1'b1
  } src_e;

  // Direct-colour word keeps red in the low byte, blue in the high byte.
  function automatic rgb_t direct_to_rgb(input logic [RGB_W-1:0] w);
    rgb_t c;
    c.red = w[COMP_W-1:0];
    c.grn = w[2*COMP_W-1:COMP_W];
    c.blu = w[3*COMP_W-1:2*COMP_W];
    return c;
  endfunction

endpackage

// File: rtl/pixmerge_classify.sv
module pixmerge_classify
  import pixmerge_pkg::*;
#(
  parameter int          TAG_W      = 8,
  parameter logic [7:0]  DIRECT_TAG = 8'h03
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [RGB_W-1:0] in_direct,
  input  mark_t            in_mark,
  output logic             s1_valid,
  output src_e             s1_src,
  output rgb_t             s1_rgb,
  output mark_t            s1_mark
);

  localparam logic [TAG_W-1:0] TAG_MATCH = TAG_W'(DIRECT_TAG);

  src_e src_d;

  always_comb begin
    src_d = (in_tag == TAG_MATCH) ? SRC_DIRECT : SRC_PALETTE;
  end

  // Stage 1: holds the pixel while the palette read is in flight.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_src   <= SRC_PALETTE;
      s1_rgb   <= '0;
      s1_mark  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_src  <= src_d;
        s1_rgb  <= direct_to_rgb(in_direct);
        s1_mark <= in_mark;
      end
    end
  end

  // A stage-1 pixel always has a predecessor input in the previous cycle.
  AST_S1_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> $past(in_valid)) else $error("stage 1 without input"); // R6

endmodule

// File: rtl/pixmerge_raster.sv
module pixmerge_raster
  import pixmerge_pkg::*;
#(
  parameter int MAX_W = 1024,
  parameter int MAX_H = 768,
  parameter int XW    = $clog2(MAX_W + 1),
  parameter int YW    = $clog2(MAX_H + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [XW-1:0] cfg_width,
  input  logic [YW-1:0] cfg_height,
  output mark_t         cur_mark
);

  localparam logic [XW-1:0] W_LIM = XW'(MAX_W);
  localparam logic [YW-1:0] H_LIM = YW'(MAX_H);

  logic [XW-1:0] eff_w, x_cnt;
  logic [YW-1:0] eff_h, y_cnt;
  logic          last_x, last_y;

  // Zero or out-of-range sizes fall back to the full window.
  always_comb begin
    eff_w = (cfg_width  == '0 || cfg_width  > W_LIM) ? W_LIM : cfg_width;
    eff_h = (cfg_height == '0 || cfg_height > H_LIM) ? H_LIM : cfg_height;
  end

  assign last_x = (x_cnt == eff_w - XW'(1));
  assign last_y = (y_cnt == eff_h - YW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      x_cnt <= '0;
      y_cnt <= '0;
    end else if (adv) begin
      if (last_x) begin
        x_cnt <= '0;
        y_cnt <= last_y ? '0 : y_cnt + YW'(1);
      end else begin
        x_cnt <= x_cnt + XW'(1);
      end
    end
  end

  always_comb begin
    cur_mark.sol = (x_cnt == '0);
    cur_mark.eol = last_x;
    cur_mark.eof = last_x && last_y;
  end

  AST_X_BOUND: assert property (@(posedge clk) disable iff (rst)
    x_cnt < eff_w) else $error("column past active width"); // R8

  AST_Y_BOUND: assert property (@(posedge clk) disable iff (rst)
    y_cnt < eff_h) else $error("row past active height"); // R9

  AST_WRAP_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    adv && cur_mark.eof |=> (x_cnt == '0) && (y_cnt == '0)) else $error("no wrap after frame end"); // R9

endmodule

// File: rtl/pixmerge_pack.sv
module pixmerge_pack
  import pixmerge_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_bgr,
  input  logic              s1_valid,
  input  src_e              s1_src,
  input  rgb_t              s1_rgb,
  input  mark_t             s1_mark,
  input  rgb_t              pal_rgb,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_pixel,
  output mark_t             out_mark
);

  localparam int PAD_W = WORD_W - RGB_W;

  rgb_t             sel;
  comp_t            chan [NCOMP];
  logic [RGB_W-1:0] lanes;

  assign sel     = (s1_src == SRC_DIRECT) ? s1_rgb : pal_rgb;
  assign chan[0] = sel.red;
  assign chan[1] = sel.grn;
  assign chan[2] = sel.blu;

  // Lane j of the output: blue-first puts channel j there, red-first mirrors.
  for (genvar j = 0; j < NCOMP; j++) begin : g_lane
    assign lanes[j*COMP_W +: COMP_W] = cfg_bgr ? chan[j] : chan[NCOMP-1-j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
      out_mark  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_mark  <= s1_valid ? s1_mark : '0;
      if (s1_valid) begin
        out_pixel <= {{PAD_W{1'b0}}, lanes};
      end
    end
  end

  AST_MARK_QUAL: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_mark == '0)) else $error("marker without pixel"); // R11

endmodule

// File: rtl/pixmerge.sv
module pixmerge
  import pixmerge_pkg::*;
#(
  parameter int         MAX_W      = 1024,
  parameter int         MAX_H      = 768,
  parameter int         IDX_W      = 8,
  parameter int         TAG_W      = 8,
  parameter int         WORD_W     = 32,
  parameter logic [7:0] DIRECT_TAG = 8'h03,
  localparam int        XW         = $clog2(MAX_W + 1),
  localparam int        YW         = $clog2(MAX_H + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_bgr,
  input  logic [XW-1:0]     cfg_width,
  input  logic [YW-1:0]     cfg_height,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  in_index,
  input  logic [RGB_W-1:0]  in_direct,
  input  logic [TAG_W-1:0]  in_ctrl_tag,
  output logic              pal_rd_en,
  output logic [IDX_W-1:0]  pal_rd_addr,
  input  logic [RGB_W-1:0]  pal_rd_data,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_pixel,
  output logic              out_sol,
  output logic              out_eol,
  output logic              out_eof
);

  localparam logic [TAG_W-1:0] TAG_MATCH = TAG_W'(DIRECT_TAG);

  mark_t cur_mark, s1_mark, o_mark;
  logic  s1_valid;
  src_e  s1_src;
  rgb_t  s1_rgb;

  // Palette read is issued with the pixel; data returns after one edge.
  assign pal_rd_en   = in_valid;
  assign pal_rd_addr = in_index;

  pixmerge_raster #(
    .MAX_W (MAX_W),
    .MAX_H (MAX_H),
    .XW    (XW),
    .YW    (YW)
  ) u_raster (
    .clk        (clk),
    .rst        (rst),
    .adv        (in_valid),
    .cfg_width  (cfg_width),
    .cfg_height (cfg_height),
    .cur_mark   (cur_mark)
  );

  pixmerge_classify #(
    .TAG_W      (TAG_W),
    .DIRECT_TAG (DIRECT_TAG)
  ) u_classify (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_tag    (in_ctrl_tag),
    .in_direct (in_direct),
    .in_mark   (cur_mark),
    .s1_valid  (s1_valid),
    .s1_src    (s1_src),
    .s1_rgb    (s1_rgb),
    .s1_mark   (s1_mark)
  );

  pixmerge_pack #(
    .WORD_W (WORD_W)
  ) u_pack (
    .clk       (clk),
    .rst       (rst),
    .cfg_bgr   (cfg_bgr),
    .s1_valid  (s1_valid),
    .s1_src    (s1_src),
    .s1_rgb    (s1_rgb),
    .s1_mark   (s1_mark),
    .pal_rgb   (rgb_t'(pal_rd_data)),
    .out_valid (out_valid),
    .out_pixel (out_pixel),
    .out_mark  (o_mark)
  );

  assign out_sol = o_mark.sol;
  assign out_eol = o_mark.eol;
  assign out_eof = o_mark.eof;

  AST_LAT_FWD: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid) else $error("pixel not delivered"); // R6

  AST_LAT_BACK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2)) else $error("spurious output"); // R6

  AST_DIRECT_RGB: assert property (@(posedge clk) disable iff (rst)
    out_valid && !cfg_bgr && ($past(in_ctrl_tag, 2) == TAG_MATCH) |->
      out_pixel[RGB_W-1:0] == {$past(in_direct[7:0], 2), $past(in_direct[15:8], 2),
                               $past(in_direct[23:16], 2)})
    else $error("direct colour mismatch"); // R1

  AST_PAL_RGB: assert property (@(posedge clk) disable iff (rst)
    out_valid && !cfg_bgr && ($past(in_ctrl_tag, 2) != TAG_MATCH) |->
      out_pixel[RGB_W-1:0] == $past(pal_rd_data))
    else $error("palette colour mismatch"); // R2

  AST_PAL_BGR: assert property (@(posedge clk) disable iff (rst)
    out_valid && cfg_bgr && ($past(in_ctrl_tag, 2) != TAG_MATCH) |->
      out_pixel[RGB_W-1:0] == {$past(pal_rd_data[7:0]), $past(pal_rd_data[15:8]),
                               $past(pal_rd_data[23:16])})
    else $error("blue-first order mismatch"); // R4

  AST_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_pixel[WORD_W-1:RGB_W] == '0) else $error("top byte not zero"); // R5

  AST_EOF_IS_EOL: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> out_eol) else $error("frame end off line end"); // R9

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_pixel) |-> out_valid) else $error("pixel changed while idle"); // R11

endmodule

// File: tb/pixmerge_tb.sv
module pixmerge_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_bgr = 1'b0;
  logic [10:0] cfg_width = 11'd8;
  logic [9:0]  cfg_height = 10'd4;
  logic        in_valid = 1'b0;
  logic [7:0]  in_index = '0;
  logic [23:0] in_direct = '0;
  logic [7:0]  in_ctrl_tag = '0;
  logic        pal_rd_en;
  logic [7:0]  pal_rd_addr;
  logic [23:0] pal_rd_data = '0;
  logic        out_valid;
  logic [31:0] out_pixel;
  logic        out_sol, out_eol, out_eof;

  always #10 clk = ~clk;

  pixmerge u_dut (
    .clk(clk), .rst(rst), .cfg_bgr(cfg_bgr), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .in_valid(in_valid), .in_index(in_index),
    .in_direct(in_direct), .in_ctrl_tag(in_ctrl_tag), .pal_rd_en(pal_rd_en),
    .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data), .out_valid(out_valid),
    .out_pixel(out_pixel), .out_sol(out_sol), .out_eol(out_eol), .out_eof(out_eof)
  );

  // Palette model: red 23:16, green 15:8, blue 7:0.
  function automatic logic [23:0] pal_of(input logic [7:0] i);
    return {i ^ 8'hA5, i + 8'd17, ~i};
  endfunction

  always @(posedge clk) if (pal_rd_en) pal_rd_data <= pal_of(pal_rd_addr);

  function automatic logic [31:0] exp_pix(input logic [7:0] tag, input logic [23:0] d,
                                          input logic [7:0] idx, input logic bgr);
    logic [7:0] r, g, b;
    if (tag == 8'h03) begin
      r = d[7:0]; g = d[15:8]; b = d[23:16];
    end else begin
      {r, g, b} = pal_of(idx);
    end
    return bgr ? {8'h00, b, g, r} : {8'h00, r, g, b};
  endfunction

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  string cur_req = "R7";
  int    bx = 0, by = 0, bw = 8, bh = 4;
  logic [34:0] exp_q[$];
  logic [34:0] got_e;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Output monitor: one expected entry per delivered pixel, in order.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, {29'd0, out_eof, out_eol, out_sol, out_pixel}, 64'd0);
      end else begin
        got_e = exp_q.pop_front();
        check({out_eof, out_eol, out_sol, out_pixel} == got_e, cur_req,
              {29'd0, out_eof, out_eol, out_sol, out_pixel}, {29'd0, got_e});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL R6 watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic do_reset(input logic [10:0] w, input logic [9:0] h, input logic bgr);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    cfg_width = w; cfg_height = h; cfg_bgr = bgr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    bx = 0; by = 0;
    bw = (w == 0 || w > 1024) ? 1024 : int'(w);
    bh = (h == 0 || h > 768) ? 768 : int'(h);
    check(out_valid == 1'b0 && {out_sol, out_eol, out_eof} == 3'b000 && out_pixel == 32'd0,
          "R7", {28'd0, out_valid, out_sol, out_eol, out_eof, out_pixel}, 64'd0);
  endtask

  task automatic send(input logic [7:0] tag, input logic [23:0] d, input logic [7:0] idx);
    logic sol, eol, eof;
    @(negedge clk);
    in_valid = 1'b1; in_ctrl_tag = tag; in_direct = d; in_index = idx;
    sol = (bx == 0);
    eol = (bx == bw - 1);
    eof = eol && (by == bh - 1);
    exp_q.push_back({eof, eol, sol, exp_pix(tag, d, idx, cfg_bgr)});
    if (eol) begin
      bx = 0;
      by = (by == bh - 1) ? 0 : by + 1;
    end else begin
      bx++;
    end
    #1;
    check(pal_rd_en && pal_rd_addr == idx, "R3", {55'd0, pal_rd_en, pal_rd_addr},
          {55'd1, idx});
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, cur_req, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic t_reset();
    cur_req = "R7";
    do_reset(11'd4, 10'd2, 1'b0);
    send(8'h00, 24'h0, 8'h10);   // first pixel after reset must carry sol
    drain();
  endtask

  task automatic t_direct();
    cur_req = "R1";
    do_reset(11'd8, 10'd4, 1'b0);
    send(8'h03, 24'h112233, 8'h00);
    send(8'h03, 24'hFF0000, 8'h44);
    send(8'h03, 24'h00FF00, 8'h55);
    send(8'h03, 24'h0000FF, 8'hFF);
    drain();
  endtask

  task automatic t_palette();
    cur_req = "R2";
    do_reset(11'd8, 10'd4, 1'b0);
    send(8'h00, 24'hABCDEF, 8'h00);
    send(8'h02, 24'hABCDEF, 8'h01);
    send(8'h07, 24'hABCDEF, 8'h7F);
    send(8'h13, 24'hABCDEF, 8'h80);
    send(8'h83, 24'hABCDEF, 8'hFE);
    send(8'hFF, 24'hABCDEF, 8'hFF);
    drain();
  endtask

  task automatic t_bgr();
    cur_req = "R4";
    do_reset(11'd8, 10'd4, 1'b1);
    send(8'h03, 24'h123456, 8'h00);
    send(8'h01, 24'h000000, 8'h3C);
    send(8'h03, 24'hC0FFEE, 8'h99);
    send(8'h00, 24'hC0FFEE, 8'hA5);
    drain();
  endtask

  task automatic t_topbyte();
    cur_req = "R5";
    do_reset(11'd8, 10'd4, 1'b0);
    for (int k = 0; k < 8; k++) send((k % 2) ? 8'h03 : 8'hF0, 24'hFFFFFF, 8'hFF - 8'(k));
    drain();
  endtask

  task automatic t_latency();
    cur_req = "R6";
    do_reset(11'd8, 10'd4, 1'b0);
    send(8'h03, 24'h0A0B0C, 8'h21);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R6", 64'(out_valid), 64'd0);
    @(negedge clk);
    check(out_valid == 1'b1, "R6", 64'(out_valid), 64'd1);
    for (int k = 0; k < 12; k++) send((k % 3 == 0) ? 8'h03 : 8'h04, 24'(k * 24'h010203), 8'(k * 7));
    drain();
  endtask

  task automatic t_raster();
    cur_req = "R8";
    do_reset(11'd5, 10'd3, 1'b0);
    for (int k = 0; k < 17; k++) send(8'h00, 24'h0, 8'(k));
    drain();
    cur_req = "R9";
    for (int k = 0; k < 13; k++) send(8'h03, 24'(k), 8'(k));
    drain();
  endtask

  task automatic t_clamp();
    cur_req = "R10";
    do_reset(11'd0, 10'd2, 1'b0);
    for (int k = 0; k < 2050; k++) send((k % 5 == 0) ? 8'h03 : 8'h00, 24'(k * 13), 8'(k));
    drain();
    do_reset(11'd2000, 10'd1, 1'b1);
    for (int k = 0; k < 1026; k++) send(8'h00, 24'h0, 8'(k * 3));
    drain();
    do_reset(11'd1, 10'd900, 1'b0);
    for (int k = 0; k < 770; k++) send(8'h03, 24'(k), 8'(k));
    drain();
    do_reset(11'd1, 10'd0, 1'b0);
    for (int k = 0; k < 769; k++) send(8'h00, 24'h0, 8'(k));
    drain();
  endtask

  task automatic t_hold();
    logic [31:0] held;
    cur_req = "R11";
    do_reset(11'd8, 10'd4, 1'b0);
    send(8'h03, 24'h123456, 8'h00);
    drain();
    held = exp_pix(8'h03, 24'h123456, 8'h00, 1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_ctrl_tag = 8'(k); in_direct = 24'hFFFFFF; in_index = 8'(k + 9);
      check(out_pixel == held && !out_valid && {out_sol, out_eol, out_eof} == 3'b000, "R11",
            {28'd0, out_valid, out_sol, out_eol, out_eof, out_pixel}, {32'd0, held});
    end
  endtask

  initial begin
    t_reset();
    t_direct();
    t_palette();
    t_bgr();
    t_topbyte();
    t_latency();
    t_raster();
    t_clamp();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule